// File: doc/BRIEF.md
# Dynamic Voltage Setpoint Selector

This block chooses which output-voltage code a step-down regulator should follow and turns that code into a target voltage expressed in microvolts. Software programs it through a small register-write port. The port holds a direct setpoint, four preset codes, a pending range bit and a control word made of two 4-bit fields. Two select pins, each passed through a two-flop synchroniser, can pick one of the presets. The block then drives the direct setpoint so that it always matches the preset in use.

The range bit switches between a fine low range and a wider high range. A new range value waits until the next setpoint update before it takes effect. An update is any write to a setpoint, preset or control register, or a change on a select pin that is in use. A one-cycle strobe marks every change of the active code or the active range. A discharge flag tells the power stage to pull its output down while the regulator is disabled.

Top module: `dvs_setpoint_sel`

## Requirements
- R1: In low range (active range 0) the target is 400000 µV + 12500 µV × code, and codes above 94 give 1575000 µV.
- R2: In high range (active range 1) codes 0 to 111 give 400000 µV + 25000 µV × code.
- R3: In high range codes 112 to 120 give 3200000 µV + 50000 µV × (code − 112), and codes above 120 give 3600000 µV.
- R4: A write of wr_data[0] to address 5 sets the pending range but leaves the active range unchanged. The pending value becomes active only on the next update. An update is a write to address 0 to 4 or 6, or a change on a select pin that is in use.
- R5: The control word is written at address 6, with field A in wr_data[3:0] and field B in wr_data[7:4]. When field A is not 4'b0010, the active code is the direct setpoint (address 0, wr_data[6:0]) and the select pins have no effect.
- R6: When field A is 4'b0010 and field B is not, sel_pin1 low selects preset 1 (address 1) and sel_pin1 high selects preset 2 (address 2). sel_pin2 is ignored.
- R7: When both fields are 4'b0010, the index {sel_pin2, sel_pin1} selects a preset: 00 gives preset 1, 01 gives preset 2, 10 gives preset 3 (address 3), and 11 gives preset 4 (address 4).
- R8: While a pin mode is active, the presets stay writable and take effect on the write. setpoint_rdback always equals the active preset code, and a write to address 0 is overwritten.
- R9: discharge_en is high one cycle after reg_enable is sampled low, and low one cycle after reg_enable is sampled high.
- R10: update_stb is high for exactly one cycle after each clock edge that changes the active code or the active range. A write that leaves both unchanged gives no strobe.
- R11: After reset the mode is register-only, all codes are 0, the active range is low, the target is 400000 µV, and update_stb and discharge_en are low.
- R12: A write takes effect at the clock edge that samples it. A select-pin change reaches active_code at the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 direct setpoint, 1 to 4 presets, 5 range, 6 control word |
| wr_data | input | 8 | Write data |
| sel_pin1 | input | 1 | Asynchronous select pin, index bit 0 |
| sel_pin2 | input | 1 | Asynchronous select pin, index bit 1 |
| reg_enable | input | 1 | Regulator enable |
| active_code | output | 7 | Active setpoint code |
| active_range | output | 1 | Active range (0 low, 1 high) |
| target_uv | output | 22 | Target voltage in microvolts |
| setpoint_rdback | output | 7 | Readback of the direct setpoint register |
| update_stb | output | 1 | One-cycle strobe on a change of active code or range |
| discharge_en | output | 1 | Output discharge request |

## Verification
The bench builds the block with its default parameters. These are a 7-bit code, steps of 12.5, 25 and 50 mV, and segment ends at codes 94, 111 and 120. With these values the whole code space is reachable in both ranges, including the codes that saturate above each range's top. Random writes, control words biased toward the pin-select value, and random pin levels move the block through all three control modes. Across these, the bench follows the deferred range, the preset selection and the readback overwrite. Directed cases cover the segment boundaries, the synchroniser latency and the strobe behaviour.

// File: rtl/dvs_pkg.sv
// Package: shared constants and types for the setpoint selector.
// Assumes: a 3-bit register address space and an 8-bit data word.
package dvs_pkg;
    localparam int CODE_W   = 7;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int UV_W     = 22;
    localparam int CFG_W    = 4;
    localparam int N_PRESET = 4;

    localparam logic [CFG_W-1:0] CFG_PIN_SEL = 4'b0010;

    localparam logic [ADDR_W-1:0] A_DIRECT = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRE1   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRE4   = 3'd4;
    localparam logic [ADDR_W-1:0] A_RANGE  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd6;

    typedef enum logic [1:0] {
        MODE_REG     = 2'd0,
        MODE_ONE_PIN = 2'd1,
        MODE_TWO_PIN = 2'd2
    } ctl_mode_e;

    // Decode the two control fields into a control mode.
    function automatic ctl_mode_e decode_mode(input logic [CFG_W-1:0] fa,
                                              input logic [CFG_W-1:0] fb);
        if (fa != CFG_PIN_SEL)      return MODE_REG;
        else if (fb != CFG_PIN_SEL) return MODE_ONE_PIN;
        else                        return MODE_TWO_PIN;
    endfunction
endpackage

// File: rtl/dvs_pin_sync.sv
// Module: two-flop synchroniser for a bundle of asynchronous select pins.
// Assumes: each pin is a slow level signal, so the bits need not be coherent.
module dvs_pin_sync #(
    parameter int N_PINS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_async,
    output logic [N_PINS-1:0] pin_sync
);
    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        logic meta_q;
        logic sync_q;
        // Two-stage capture of one pin into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= pin_async[g];
                sync_q <= meta_q;
            end
        end
        assign pin_sync[g] = sync_q;
    end
endmodule

// File: rtl/dvs_setpoint_bank.sv
// Module: register bank for the direct setpoint, presets, pending range and
// control word. It also computes the next active code.
// Assumes: writes and pin values are sampled at the same edge. In a pin mode
// the direct setpoint is rewritten each cycle with the selected preset.
module dvs_setpoint_bank
    import dvs_pkg::*;
#(
    parameter int C_W = CODE_W,
    parameter int A_W = ADDR_W,
    parameter int D_W = DATA_W,
    parameter int N_P = N_PRESET
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [A_W-1:0] wr_addr,
    input  logic [D_W-1:0] wr_data,
    input  logic [1:0]     pin_sync,
    output logic [C_W-1:0] sel_code_n,
    output logic [C_W-1:0] direct_q,
    output logic           range_pend_n,
    output ctl_mode_e      mode_q,
    output logic           wr_update
);
    localparam int IDX_W = $clog2(N_P);

    logic [C_W-1:0]   preset_q [N_P];
    logic [C_W-1:0]   preset_n [N_P];
    logic [CFG_W-1:0] fa_q, fb_q, fa_n, fb_n;
    logic             range_pend_q;
    logic [C_W-1:0]   direct_w;
    ctl_mode_e        mode_n;
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < N_P; g++) begin : g_preset
        localparam logic [A_W-1:0] MY_ADDR = A_W'(int'(A_PRE1) + g);
        // Next value of one preset after this cycle's write.
        always_comb begin
            preset_n[g] = (wr_en && wr_addr == MY_ADDR) ? wr_data[C_W-1:0] : preset_q[g];
        end
        // Storage of one preset code.
        always_ff @(posedge clk) begin
            if (!rst_n) preset_q[g] <= '0;
            else        preset_q[g] <= preset_n[g];
        end
    end

    // Next control fields, pending range and direct value after this cycle's write.
    always_comb begin
        fa_n         = (wr_en && wr_addr == A_CTRL) ? wr_data[CFG_W-1:0] : fa_q;
        fb_n         = (wr_en && wr_addr == A_CTRL) ? wr_data[2*CFG_W-1:CFG_W] : fb_q;
        range_pend_n = (wr_en && wr_addr == A_RANGE) ? wr_data[0] : range_pend_q;
        direct_w     = (wr_en && wr_addr == A_DIRECT) ? wr_data[C_W-1:0] : direct_q;
        mode_n       = decode_mode(fa_n, fb_n);
    end

    // Preset index from the synchronised pins under the next mode.
    always_comb begin
        idx = '0;
        if (mode_n == MODE_TWO_PIN)      idx = IDX_W'(pin_sync);
        else if (mode_n == MODE_ONE_PIN) idx = IDX_W'(pin_sync[0]);
    end

    // Choose the code that becomes active at this edge.
    always_comb begin
        sel_code_n = (mode_n == MODE_REG) ? direct_w : preset_n[idx];
    end

    // Flag writes that count as a setpoint update.
    always_comb begin
        wr_update = wr_en && ((wr_addr >= A_DIRECT && wr_addr <= A_PRE4) || wr_addr == A_CTRL);
    end

    // Storage of the control word, pending range and direct setpoint.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa_q         <= '0;
            fb_q         <= '0;
            range_pend_q <= 1'b0;
            direct_q     <= '0;
        end else begin
            fa_q         <= fa_n;
            fb_q         <= fb_n;
            range_pend_q <= range_pend_n;
            direct_q     <= sel_code_n;
        end
    end

    assign mode_q = decode_mode(fa_q, fb_q);

    // The direct setpoint keeps its value in register mode unless it is written.
    assert_direct_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_REG && !wr_en) |=> $stable(direct_q));
endmodule

// File: rtl/dvs_code_to_uv.sv
// Module: converts a setpoint code and a range bit into a target in microvolts.
// Assumes: codes above each range's top saturate; purely combinational.
module dvs_code_to_uv #(
    parameter int C_W        = 7,
    parameter int U_W        = 22,
    parameter int BASE_UV    = 400000,
    parameter int LO_STEP    = 12500,
    parameter int LO_TOP     = 94,
    parameter int HI_STEP    = 25000,
    parameter int HI_FINE_TOP= 111,
    parameter int HI_CO_STEP = 50000,
    parameter int HI_TOP     = 120
) (
    input  logic [C_W-1:0] code,
    input  logic           hi_range,
    output logic [U_W-1:0] uv
);
    localparam int HI_CO_START = HI_FINE_TOP + 1;
    localparam int HI_CO_BASE  = BASE_UV + HI_STEP * HI_CO_START;

    int c;
    int acc;

    // Piecewise mapping from code to microvolts with saturation.
    always_comb begin
        c = int'(code);
        if (!hi_range) begin
            if (c > LO_TOP) c = LO_TOP;
            acc = BASE_UV + c * LO_STEP;
        end else if (c <= HI_FINE_TOP) begin
            acc = BASE_UV + c * HI_STEP;
        end else begin
            if (c > HI_TOP) c = HI_TOP;
            acc = HI_CO_BASE + (c - HI_CO_START) * HI_CO_STEP;
        end
        uv = acc[U_W-1:0];
    end
endmodule

// File: rtl/dvs_setpoint_sel.sv
// Module: top of the setpoint selector. It holds the active code and active
// range, detects pin updates, drives the update strobe and the discharge flag.
// Assumes: synchronous active-low reset; pins are asynchronous levels.
module dvs_setpoint_sel
    import dvs_pkg::*;
#(
    parameter int C_W = CODE_W,
    parameter int A_W = ADDR_W,
    parameter int D_W = DATA_W,
    parameter int U_W = UV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [A_W-1:0] wr_addr,
    input  logic [D_W-1:0] wr_data,
    input  logic           sel_pin1,
    input  logic           sel_pin2,
    input  logic           reg_enable,
    output logic [C_W-1:0] active_code,
    output logic           active_range,
    output logic [U_W-1:0] target_uv,
    output logic [C_W-1:0] setpoint_rdback,
    output logic           update_stb,
    output logic           discharge_en
);
    localparam int LO_MAX_UV = 1575000;
    localparam int HI_MAX_UV = 3600000;

    logic [1:0]     pin_s;
    logic [1:0]     pin_prev_q;
    logic [C_W-1:0] sel_code_n;
    logic           range_pend_n;
    ctl_mode_e      mode_q;
    logic           wr_update;
    logic           pin_evt;
    logic           upd;
    logic           range_n;
    logic [C_W-1:0] code_q;
    logic           range_q;

    dvs_pin_sync #(.N_PINS(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async ({sel_pin2, sel_pin1}),
        .pin_sync  (pin_s)
    );

    dvs_setpoint_bank #(.C_W(C_W), .A_W(A_W), .D_W(D_W), .N_P(N_PRESET)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pin_sync     (pin_s),
        .sel_code_n   (sel_code_n),
        .direct_q     (setpoint_rdback),
        .range_pend_n (range_pend_n),
        .mode_q       (mode_q),
        .wr_update    (wr_update)
    );

    // Detect a change on a select pin that the current mode uses.
    always_comb begin
        unique case (mode_q)
            MODE_ONE_PIN: pin_evt = (pin_s[0] != pin_prev_q[0]);
            MODE_TWO_PIN: pin_evt = (pin_s != pin_prev_q);
            default:      pin_evt = 1'b0;
        endcase
        upd     = wr_update || pin_evt;
        range_n = upd ? range_pend_n : range_q;
    end

    // Active code, deferred range, previous pins, strobe and discharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q       <= '0;
            range_q      <= 1'b0;
            pin_prev_q   <= '0;
            update_stb   <= 1'b0;
            discharge_en <= 1'b0;
        end else begin
            code_q       <= sel_code_n;
            range_q      <= range_n;
            pin_prev_q   <= pin_s;
            update_stb   <= (sel_code_n != code_q) || (range_n != range_q);
            discharge_en <= !reg_enable;
        end
    end

    dvs_code_to_uv #(.C_W(C_W), .U_W(U_W)) u_conv (
        .code     (code_q),
        .hi_range (range_q),
        .uv       (target_uv)
    );

    assign active_code  = code_q;
    assign active_range = range_q;

    // Range may only move after an update.
    assert_range_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(range_q));
    // The strobe implies the code or range moved at that edge.
    assert_stb_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> (code_q != $past(code_q) || range_q != $past(range_q)));
    // The low range never exceeds its top voltage.
    assert_lo_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !range_q |-> (int'(target_uv) <= LO_MAX_UV));
    // The high range never exceeds its top voltage.
    assert_hi_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        range_q |-> (int'(target_uv) <= HI_MAX_UV));
    // In a pin mode the readback follows the active code.
    assert_rdback_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_REG) |-> (setpoint_rdback == code_q));
    // A regulator that stays enabled sees no discharge.
    assert_no_discharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_enable && $past(reg_enable)) |-> !discharge_en);
endmodule

// File: tb/dvs_setpoint_sel_test.sv
module dvs_setpoint_sel_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sel_pin1 = 1'b0;
    logic       sel_pin2 = 1'b0;
    logic       reg_enable = 1'b1;
    logic [6:0] active_code;
    logic       active_range;
    logic [21:0] target_uv;
    logic [6:0] setpoint_rdback;
    logic       update_stb;
    logic       discharge_en;

    int n_tests = 0;
    int n_fail  = 0;

    // Shadow model of the block state.
    int m_direct;
    int m_pre [4];
    int m_fa, m_fb;
    int m_rpend, m_ract;
    int m_p1, m_p2;

    dvs_setpoint_sel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_pin1(sel_pin1), .sel_pin2(sel_pin2), .reg_enable(reg_enable),
        .active_code(active_code), .active_range(active_range), .target_uv(target_uv),
        .setpoint_rdback(setpoint_rdback), .update_stb(update_stb), .discharge_en(discharge_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_uv(int c, int hr);
        if (hr == 0) begin
            if (c > 94) c = 94;
            return 400000 + c * 12500;
        end
        if (c <= 111) return 400000 + c * 25000;
        if (c <= 120) return 3200000 + (c - 112) * 50000;
        return 3600000;
    endfunction

    function automatic int m_mode();
        if (m_fa != 2) return 0;
        if (m_fb != 2) return 1;
        return 2;
    endfunction

    function automatic int m_active();
        case (m_mode())
            0: return m_direct;
            1: return m_pre[m_p1];
            default: return m_pre[m_p2 * 2 + m_p1];
        endcase
    endfunction

    function automatic string mode_req();
        case (m_mode())
            0: return "R5";
            1: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        case (addr)
            0: m_direct = data & 8'h7f;
            1, 2, 3, 4: m_pre[addr-1] = data & 8'h7f;
            5: m_rpend = data & 1;
            6: begin m_fa = data & 4'hf; m_fb = (data >> 4) & 4'hf; end
            default: ;
        endcase
        if (addr <= 4 || addr == 6) m_ract = m_rpend;
        if (m_mode() != 0) m_direct = m_active();
    endtask

    task automatic set_pins(int p1, int p2);
        int old_mode = m_mode();
        int chg;
        @(negedge clk);
        sel_pin1 = p1[0]; sel_pin2 = p2[0];
        chg = (old_mode == 1 && p1 != m_p1) || (old_mode == 2 && (p1 != m_p1 || p2 != m_p2));
        m_p1 = p1; m_p2 = p2;
        if (chg) m_ract = m_rpend;
        if (m_mode() != 0) m_direct = m_active();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_state(string req);
        int a = m_active();
        check({req, " code"}, int'(active_code), a);
        check({req, " range"}, int'(active_range), m_ract);
        check({req, " uv"}, int'(target_uv), exp_uv(a, m_ract));
        check({req, " rdback"}, int'(setpoint_rdback), m_direct);
    endtask

    // Watchdog that ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_direct = 0; m_pre = '{0, 0, 0, 0}; m_fa = 0; m_fb = 0;
        m_rpend = 0; m_ract = 0; m_p1 = 0; m_p2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check_state("R11");
        check("R11 stb", int'(update_stb), 0);
        check("R11 discharge", int'(discharge_en), 0);

        // R1: low range points and saturation
        do_write(0, 10);  check("R1 code10", int'(target_uv), 525000);
        do_write(0, 94);  check("R1 code94", int'(target_uv), 1575000);
        do_write(0, 127); check("R1 code127 sat", int'(target_uv), 1575000);

        // R4: range write deferred until the next update
        do_write(5, 1);
        check("R4 deferred range", int'(active_range), 0);
        check("R4 deferred uv", int'(target_uv), 1575000);
        do_write(0, 111);
        check("R4 applied range", int'(active_range), 1);
        check("R2 code111", int'(target_uv), 3175000);
        do_write(0, 40);  check("R2 code40", int'(target_uv), 1400000);
        do_write(0, 112); check("R3 code112", int'(target_uv), 3200000);
        do_write(0, 120); check("R3 code120", int'(target_uv), 3600000);
        do_write(0, 127); check("R3 code127 sat", int'(target_uv), 3600000);

        // R10: strobe on change only, one cycle wide
        do_write(0, 50);
        check("R10 stb on change", int'(update_stb), 1);
        @(negedge clk);
        check("R10 stb one cycle", int'(update_stb), 0);
        do_write(0, 50);
        check("R10 no stb same code", int'(update_stb), 0);

        // R6 and R12: single-pin mode and synchroniser latency
        do_write(1, 20); do_write(2, 70); do_write(3, 5); do_write(4, 99);
        do_write(6, 8'h02);
        check_state("R6");
        @(negedge clk);
        sel_pin1 = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R12 before sync", int'(active_code), 20);
        @(negedge clk);
        check("R12 after sync", int'(active_code), 70);
        m_p1 = 1; m_direct = 70;
        check("R8 rdback tracks", int'(setpoint_rdback), 70);
        set_pins(1, 1);
        check_state("R6 pin2 ignored");

        // R7: dual-pin mapping
        do_write(6, 8'h22);
        for (int i = 0; i < 4; i++) begin
            set_pins(i & 1, i >> 1);
            check_state("R7");
        end

        // R8: preset write takes effect, direct write overwritten
        do_write(4, 33);
        check_state("R8 preset write");
        do_write(0, 7);
        check_state("R8 direct overwritten");

        // R9: discharge follows enable with one cycle of delay
        @(negedge clk); reg_enable = 1'b0;
        @(negedge clk);
        check("R9 discharge on", int'(discharge_en), 1);
        reg_enable = 1'b1;
        @(negedge clk);
        check("R9 discharge off", int'(discharge_en), 0);

        // Random mix of writes and pin changes against the model.
        for (int k = 0; k < 400; k++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 3) begin
                set_pins(int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
            end else if (op == 3) begin
                int sel = int'($urandom_range(0, 3));
                int d = (sel == 0) ? 8'h22 : (sel == 1) ? 8'h02 : (sel == 2) ? 8'h20 : int'($urandom_range(0, 255));
                do_write(6, d);
            end else if (op == 4) begin
                do_write(5, int'($urandom_range(0, 255)));
            end else begin
                do_write(int'($urandom_range(0, 4)), int'($urandom_range(0, 255)));
            end
            check_state(mode_req());
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule